// File: doc/BRIEF.md
# Symbol Pair Line State Detector

This block watches a receive stream of 5-bit code symbols delivered as pairs, one pair per byte clock with a valid strobe, and classifies the link into a line state. Runs of Quiet, Halt, Halt-Quiet and Idle pairs beyond per-state run lengths put the link into the matching state. A J-K start delimiter switches the link to Active and raises a one-cycle pulse. Pairs that fit no pattern drop the link to Unknown, and a long stretch of pairs that never settles into a state is reported as Noise.

Loss of the signal-detect input or of the clock-detect input makes the detector treat every pair as Quiet, so after a full Quiet run the link reads Quiet with the no-signal flag set. Clearing the run enable, or asserting reset, forces Unknown with the no-signal flag. The state is registered and moves only on a valid pair. A parameter selects a 3-bit encoded state output or an 8-bit one-hot output in which bit n stands for code n.

Top module: `symbol_line_state_det`

## Requirements
- R1: During reset, and one cycle after any cycle with run_en low, line_state is Unknown (code 0), no_sig is 1 and jk_pulse is 0. Run counts and the noise count are cleared.
- R2: line_state, no_sig and jk_pulse are registered. They change only on the clock edge that accepts a pair (pair_vld high). Cycles without a valid pair leave the state unchanged and drive jk_pulse to 0.
- R3: Quiet (code 1) is entered on the 8th consecutive valid pair with both symbols equal to 5'b00000.
- R4: Halt (code 2) is entered on the 8th consecutive pair 00100/00100. Master (code 3) is entered on the 8th consecutive pair with first symbol pair[9:5]=00100 and second symbol pair[4:0]=00000.
- R5: Idle (code 4) is entered on the 2nd consecutive 11111/11111 pair. Super Idle (code 5) is entered on the 9th, which is the nominal eight plus one pair of slack.
- R6: A pair with pair[9:5]=11000 and pair[4:0]=10001 moves the link to Active (code 7) and raises jk_pulse for exactly one cycle. Other pairs received in Active keep Active until some state's run length is reached.
- R7: One pair that does not match the current recognised state, and completes no run, moves the state to Unknown.
- R8: Noise (code 6) is entered when 16 valid pairs arrive without any state being recognised. Noise is held until a state's run length is reached.
- R9: The noise count keeps running across unknown pairs of differing kinds. Entering or staying in a recognised state clears it. A run count restarts at one whenever the pair kind changes.
- R10: While sig_det or clk_det is low, every valid pair counts as a Quiet pair. no_sig is 1 exactly when such a pair leaves the state at Quiet. It clears on the next pair that arrives with both detects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low forces Unknown with no_sig |
| sig_det | input | 1 | Signal detect from the receiver |
| clk_det | input | 1 | Recovered-clock present indication |
| pair_vld | input | 1 | Symbol pair valid strobe |
| pair | input | 10 | Symbol pair, first symbol in [9:5] |
| line_state | output | 3 (8 if one-hot) | Current line state |
| no_sig | output | 1 | No-signal-detect flag |
| jk_pulse | output | 1 | One-cycle start delimiter pulse |

## Verification
The hardest situation to reach is a Noise entry built from several partial runs. No single pair kind repeats often enough to be recognised, yet the noise count must carry across all of them. The stimulus sends seven Halt pairs, then seven Halt-Quiet pairs, then odd pairs, and checks that the 16th pair, not the 15th, enters Noise. It then shows the count was cleared by reaching Quiet: after Quiet, fifteen odd pairs leave the link at Unknown.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
   typedef enum logic [2:0] {
      LS_UNKNOWN    = 3'd0,
      LS_QUIET      = 3'd1,
      LS_HALT       = 3'd2,
      LS_MASTER     = 3'd3,
      LS_IDLE       = 3'd4,
      LS_SUPER_IDLE = 3'd5,
      LS_NOISE      = 3'd6,
      LS_ACTIVE     = 3'd7
   } line_state_e;

   typedef enum logic [2:0] {
      PC_NONE  = 3'd0,
      PC_OTHER = 3'd1,
      PC_QQ    = 3'd2,
      PC_HH    = 3'd3,
      PC_HQ    = 3'd4,
      PC_II    = 3'd5,
      PC_JK    = 3'd6
   } pair_class_e;

   localparam logic [4:0] SYM_Q = 5'b00000;
   localparam logic [4:0] SYM_I = 5'b11111;
   localparam logic [4:0] SYM_H = 5'b00100;
   localparam logic [4:0] SYM_J = 5'b11000;
   localparam logic [4:0] SYM_K = 5'b10001;
endpackage

// File: rtl/lsd_pair_class.sv
module lsd_pair_class
   import lsd_pkg::*;
#(
   parameter int SYM_W = 5
) (
   input  logic [2*SYM_W-1:0] pair,
   input  logic               force_quiet,
   output pair_class_e        cls
);
   logic [SYM_W-1:0] first_sym;
   logic [SYM_W-1:0] second_sym;

   assign first_sym  = pair[2*SYM_W-1:SYM_W];
   assign second_sym = pair[SYM_W-1:0];

   always_comb begin
      if (force_quiet)
         cls = PC_QQ;
      else if (first_sym == SYM_Q && second_sym == SYM_Q)
         cls = PC_QQ;
      else if (first_sym == SYM_H && second_sym == SYM_H)
         cls = PC_HH;
      else if (first_sym == SYM_H && second_sym == SYM_Q)
         cls = PC_HQ;
      else if (first_sym == SYM_I && second_sym == SYM_I)
         cls = PC_II;
      else if (first_sym == SYM_J && second_sym == SYM_K)
         cls = PC_JK;
      else
         cls = PC_OTHER;
   end
endmodule

// File: rtl/lsd_run_track.sv
module lsd_run_track
   import lsd_pkg::*;
#(
   parameter int RUN_MAX = 9,
   localparam int CNT_W  = $clog2(RUN_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             adv,
   input  pair_class_e      cls,
   output logic [CNT_W-1:0] run_next
);
   pair_class_e      prev_q;
   logic [CNT_W-1:0] run_q;

   always_comb begin
      if (cls != prev_q)
         run_next = CNT_W'(1);
      else if (run_q == CNT_W'(RUN_MAX))
         run_next = run_q;
      else
         run_next = run_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= PC_NONE;
         run_q  <= '0;
      end else if (clear) begin
         prev_q <= PC_NONE;
         run_q  <= '0;
      end else if (adv) begin
         prev_q <= cls;
         run_q  <= run_next;
      end
   end
endmodule

// File: rtl/lsd_state_fsm.sv
module lsd_state_fsm
   import lsd_pkg::*;
#(
   parameter int QUIET_RUN  = 8,
   parameter int HALT_RUN   = 8,
   parameter int MASTER_RUN = 8,
   parameter int IDLE_RUN   = 2,
   parameter int SIDLE_RUN  = 8,
   parameter int SIDLE_SLACK = 1,
   parameter int NOISE_RUN  = 16,
   parameter int CNT_W      = 4,
   localparam int NZ_W      = $clog2(NOISE_RUN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             adv,
   input  logic             loss,
   input  pair_class_e      cls,
   input  logic [CNT_W-1:0] run_next,
   output line_state_e      st,
   output logic             no_sig,
   output logic             jk_pulse
);
   localparam int SI_ENTRY = SIDLE_RUN + SIDLE_SLACK;

   line_state_e     st_q, st_d, tgt;
   logic [NZ_W-1:0] noise_q, noise_d, noise_inc;
   logic            nsd_q, nsd_d, jk_q, jk_d;
   logic            hit, fits;

   always_comb begin
      hit = 1'b1;
      tgt = st_q;
      if (cls == PC_JK)
         tgt = LS_ACTIVE;
      else if (cls == PC_QQ && run_next >= CNT_W'(QUIET_RUN))
         tgt = LS_QUIET;
      else if (cls == PC_HH && run_next >= CNT_W'(HALT_RUN))
         tgt = LS_HALT;
      else if (cls == PC_HQ && run_next >= CNT_W'(MASTER_RUN))
         tgt = LS_MASTER;
      else if (cls == PC_II && run_next >= CNT_W'(SI_ENTRY))
         tgt = LS_SUPER_IDLE;
      else if (cls == PC_II && run_next >= CNT_W'(IDLE_RUN))
         tgt = LS_IDLE;
      else
         hit = 1'b0;
   end

   always_comb begin
      case (st_q)
         LS_ACTIVE:                fits = 1'b1;
         LS_QUIET:                 fits = (cls == PC_QQ);
         LS_HALT:                  fits = (cls == PC_HH);
         LS_MASTER:                fits = (cls == PC_HQ);
         LS_IDLE, LS_SUPER_IDLE:   fits = (cls == PC_II);
         default:                  fits = 1'b0;
      endcase
   end

   assign noise_inc = (noise_q == NZ_W'(NOISE_RUN)) ? noise_q : noise_q + NZ_W'(1);

   always_comb begin
      st_d    = st_q;
      noise_d = noise_q;
      nsd_d   = nsd_q;
      jk_d    = 1'b0;
      if (adv) begin
         if (hit) begin
            st_d    = tgt;
            noise_d = '0;
         end else if (fits) begin
            noise_d = '0;
         end else begin
            noise_d = noise_inc;
            st_d    = (st_q == LS_NOISE || noise_inc == NZ_W'(NOISE_RUN))
                      ? LS_NOISE : LS_UNKNOWN;
         end
         jk_d  = (cls == PC_JK);
         nsd_d = loss && (st_d == LS_QUIET);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= LS_UNKNOWN;
         noise_q <= '0;
         nsd_q   <= 1'b1;
         jk_q    <= 1'b0;
      end else if (!run_en) begin
         st_q    <= LS_UNKNOWN;
         noise_q <= '0;
         nsd_q   <= 1'b1;
         jk_q    <= 1'b0;
      end else begin
         st_q    <= st_d;
         noise_q <= noise_d;
         nsd_q   <= nsd_d;
         jk_q    <= jk_d;
      end
   end

   assign st       = st_q;
   assign no_sig   = nsd_q;
   assign jk_pulse = jk_q;
endmodule

// File: rtl/symbol_line_state_det.sv
module symbol_line_state_det
   import lsd_pkg::*;
#(
   parameter int SYM_W       = 5,
   parameter int QUIET_RUN   = 8,
   parameter int HALT_RUN    = 8,
   parameter int MASTER_RUN  = 8,
   parameter int IDLE_RUN    = 2,
   parameter int SIDLE_RUN   = 8,
   parameter int SIDLE_SLACK = 1,
   parameter int NOISE_RUN   = 16,
   parameter bit ONEHOT_OUT  = 1'b0,
   localparam int ST_OUT_W   = ONEHOT_OUT ? 8 : 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_en,
   input  logic                sig_det,
   input  logic                clk_det,
   input  logic                pair_vld,
   input  logic [2*SYM_W-1:0]  pair,
   output logic [ST_OUT_W-1:0] line_state,
   output logic                no_sig,
   output logic                jk_pulse
);
   localparam int MAX_QH  = (QUIET_RUN > HALT_RUN) ? QUIET_RUN : HALT_RUN;
   localparam int MAX_QHM = (MAX_QH > MASTER_RUN) ? MAX_QH : MASTER_RUN;
   localparam int SI_ENT  = SIDLE_RUN + SIDLE_SLACK;
   localparam int RUN_MAX = (MAX_QHM > SI_ENT) ? MAX_QHM : SI_ENT;
   localparam int CNT_W   = $clog2(RUN_MAX + 1);

   initial begin
      assert (SYM_W == 5) else $error("symbol width must be 5");
      assert (IDLE_RUN >= 1 && IDLE_RUN < SI_ENT)
         else $error("idle run must be below super idle entry");
      assert (NOISE_RUN >= 2) else $error("noise run too short");
      assert (QUIET_RUN >= 1 && HALT_RUN >= 1 && MASTER_RUN >= 1)
         else $error("run lengths must be positive");
   end

   pair_class_e      cls;
   logic             loss;
   logic             adv;
   logic [CNT_W-1:0] run_next;
   line_state_e      st;

   assign loss = !sig_det || !clk_det;
   assign adv  = pair_vld && run_en;

   lsd_pair_class #(.SYM_W(SYM_W)) u_class (
      .pair        (pair),
      .force_quiet (loss),
      .cls         (cls)
   );

   lsd_run_track #(.RUN_MAX(RUN_MAX)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (!run_en),
      .adv      (adv),
      .cls      (cls),
      .run_next (run_next)
   );

   lsd_state_fsm #(
      .QUIET_RUN   (QUIET_RUN),
      .HALT_RUN    (HALT_RUN),
      .MASTER_RUN  (MASTER_RUN),
      .IDLE_RUN    (IDLE_RUN),
      .SIDLE_RUN   (SIDLE_RUN),
      .SIDLE_SLACK (SIDLE_SLACK),
      .NOISE_RUN   (NOISE_RUN),
      .CNT_W       (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .adv      (adv),
      .loss     (loss),
      .cls      (cls),
      .run_next (run_next),
      .st       (st),
      .no_sig   (no_sig),
      .jk_pulse (jk_pulse)
   );

   generate
      if (ONEHOT_OUT) begin : g_onehot
         assign line_state = ST_OUT_W'(1) << st;
      end else begin : g_encoded
         assign line_state = st;
      end
   endgenerate
endmodule

// File: rtl/lsd_checker.sv
module lsd_checker
   import lsd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       run_en,
   input logic       pair_vld,
   input logic [2:0] st,
   input logic       no_sig,
   input logic       jk_pulse
);
   a_r1_run_off_forces_unknown: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (st == LS_UNKNOWN) && no_sig && !jk_pulse);

   a_r2_hold_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !pair_vld) |=> $stable(st) && !jk_pulse);

   a_r2_change_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(st) && $past(run_en)) |-> $past(pair_vld));

   a_r5_super_idle_via_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LS_SUPER_IDLE) |-> ($past(st) == LS_IDLE || $past(st) == LS_SUPER_IDLE));

   a_r6_pulse_in_active: assert property (@(posedge clk) disable iff (!rst_n)
      jk_pulse |-> (st == LS_ACTIVE));

   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      jk_pulse |=> !jk_pulse || $past(pair_vld));

   a_r10_nosig_with_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      no_sig |-> (st == LS_QUIET || st == LS_UNKNOWN));
endmodule

bind symbol_line_state_det lsd_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .pair_vld (pair_vld),
   .st       (st),
   .no_sig   (no_sig),
   .jk_pulse (jk_pulse)
);

// File: tb/symbol_line_state_det_tb.sv
`timescale 1ns/1ps
module symbol_line_state_det_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic       sig_det = 1'b1;
   logic       clk_det = 1'b1;
   logic       pair_vld = 1'b0;
   logic [9:0] pair = 10'd0;
   logic [2:0] line_state;
   logic       no_sig;
   logic       jk_pulse;

   int total = 0;
   int bad = 0;

   localparam logic [9:0] P_QQ  = 10'b00000_00000;
   localparam logic [9:0] P_HH  = 10'b00100_00100;
   localparam logic [9:0] P_HQ  = 10'b00100_00000;
   localparam logic [9:0] P_II  = 10'b11111_11111;
   localparam logic [9:0] P_JK  = 10'b11000_10001;
   localparam logic [9:0] P_ODD = 10'b10101_00101;
   localparam logic [9:0] P_DAT = 10'b01010_10101;

   always #2.5 clk = ~clk;

   symbol_line_state_det u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .sig_det(sig_det),
      .clk_det(clk_det), .pair_vld(pair_vld), .pair(pair),
      .line_state(line_state), .no_sig(no_sig), .jk_pulse(jk_pulse)
   );

   // behavioural reference: 0 other,1 QQ,2 HH,3 HQ,4 II,5 JK
   int m_st = 0;
   int m_nsd = 1;
   int m_jk = 0;
   int m_noise = 0;
   int hist[$];

   function automatic int kind_of(logic [9:0] p, logic lost);
      if (lost) return 1;
      if (p == P_QQ) return 1;
      if (p == P_HH) return 2;
      if (p == P_HQ) return 3;
      if (p == P_II) return 4;
      if (p == P_JK) return 5;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n || !run_en) begin
         m_st = 0; m_nsd = 1; m_jk = 0; m_noise = 0;
         hist.delete();
      end else if (pair_vld) begin
         int k, run, nxt;
         bit lost, hit, fit;
         lost = !sig_det || !clk_det;
         k = kind_of(pair, lost);
         hist.push_back(k);
         if (hist.size() > 40) void'(hist.pop_front());
         run = 0;
         for (int i = hist.size() - 1; i >= 0; i--) begin
            if (hist[i] != k) break;
            run++;
         end
         hit = 1; nxt = m_st;
         if (k == 5) nxt = 7;
         else if (k == 1 && run >= 8) nxt = 1;
         else if (k == 2 && run >= 8) nxt = 2;
         else if (k == 3 && run >= 8) nxt = 3;
         else if (k == 4 && run >= 9) nxt = 5;
         else if (k == 4 && run >= 2) nxt = 4;
         else hit = 0;
         fit = (m_st == 7) || (m_st == 1 && k == 1) || (m_st == 2 && k == 2) ||
               (m_st == 3 && k == 3) || ((m_st == 4 || m_st == 5) && k == 4);
         if (hit) begin
            m_noise = 0;
         end else if (fit) begin
            m_noise = 0;
            nxt = m_st;
         end else begin
            if (m_noise < 16) m_noise++;
            nxt = (m_st == 6 || m_noise >= 16) ? 6 : 0;
         end
         m_st = nxt;
         m_jk = (k == 5);
         m_nsd = (lost && m_st == 1) ? 1 : 0;
      end else begin
         m_jk = 0;
      end
   end

   function automatic string tag_of(int s);
      case (s)
         1: return "R3";
         2, 3: return "R4";
         4, 5: return "R5";
         6: return "R8";
         7: return "R6";
         default: return "R7";
      endcase
   endfunction

   always @(negedge clk) begin
      total++;
      if (line_state !== 3'(m_st) || no_sig !== m_nsd[0] || jk_pulse !== m_jk[0]) begin
         bad++;
         $display("FAIL %s model: state=%0d nsd=%0d jk=%0d expected %0d %0d %0d",
                  tag_of(m_st), line_state, no_sig, jk_pulse, m_st, m_nsd, m_jk);
      end
   end

   task automatic chk(string tag, int es, int en, int ej);
      total++;
      if (line_state !== 3'(es) || no_sig !== en[0] || jk_pulse !== ej[0]) begin
         bad++;
         $display("FAIL %s: state=%0d nsd=%0d jk=%0d expected %0d %0d %0d",
                  tag, line_state, no_sig, jk_pulse, es, en, ej);
      end
   endtask

   task automatic send(logic [9:0] p);
      pair = p; pair_vld = 1'b1;
      @(negedge clk);
      pair_vld = 1'b0;
   endtask

   task automatic send_n(logic [9:0] p, int n);
      for (int i = 0; i < n; i++) send(p);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", 0, 1, 0);
      rst_n = 1'b1; run_en = 1'b1;
      @(negedge clk);
      // R2: quiet pairs without strobe have no effect
      pair = P_QQ;
      repeat (3) @(negedge clk);
      chk("R2 no strobe", 0, 1, 0);
      // R3
      send_n(P_QQ, 7);  chk("R3 seven quiet", 0, 0, 0);
      send(P_QQ);       chk("R3 eighth quiet", 1, 0, 0);
      // R7 single inconsistent pair
      send(P_HH);       chk("R7 one odd pair", 0, 0, 0);
      // R4 halt then master
      send_n(P_HH, 7);  chk("R4 halt", 2, 0, 0);
      send_n(P_HQ, 7);  chk("R4 seven hq", 0, 0, 0);
      send(P_HQ);       chk("R4 master", 3, 0, 0);
      // R5 idle and super idle
      send(P_II);       chk("R5 one idle", 0, 0, 0);
      send(P_II);       chk("R5 idle", 4, 0, 0);
      send_n(P_II, 6);  chk("R5 eighth idle", 4, 0, 0);
      send(P_II);       chk("R5 super idle", 5, 0, 0);
      // R6
      send(P_JK);       chk("R6 jk", 7, 0, 1);
      send(P_DAT);      chk("R6 data", 7, 0, 0);
      // R10 signal loss
      sig_det = 1'b0;
      send_n(P_DAT, 7); chk("R10 loss seven", 7, 0, 0);
      send(P_DAT);      chk("R10 loss quiet", 1, 1, 0);
      sig_det = 1'b1;
      send(P_QQ);       chk("R10 signal back", 1, 0, 0);
      // R8 noise
      send_n(P_ODD, 15); chk("R8 fifteen odd", 0, 0, 0);
      send(P_ODD);       chk("R8 noise", 6, 0, 0);
      send_n(P_QQ, 7);   chk("R8 hold noise", 6, 0, 0);
      send(P_QQ);        chk("R8 leave noise", 1, 0, 0);
      // R9 mixed partial runs
      send_n(P_HH, 7);
      send_n(P_HQ, 7);
      send(P_ODD);       chk("R9 mixed fifteen", 0, 0, 0);
      send(P_ODD);       chk("R9 mixed noise", 6, 0, 0);
      send_n(P_QQ, 8);   chk("R9 quiet again", 1, 0, 0);
      send_n(P_ODD, 15); chk("R9 count cleared", 0, 0, 0);
      send(P_ODD);       chk("R9 noise again", 6, 0, 0);
      // R1 run enable
      @(negedge clk); run_en = 1'b0;
      @(negedge clk);    chk("R1 run off", 0, 1, 0);
      run_en = 1'b1;
      // R10 clock detect loss
      clk_det = 1'b0;
      send_n(P_II, 8);   chk("R10 clock loss", 1, 1, 0);
      clk_det = 1'b1;
      send(P_JK);        chk("R6 jk from quiet", 7, 0, 1);
      @(negedge clk);    chk("R6 pulse ends", 7, 0, 0);
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule